// File: doc/BRIEF.md
# UART Register and Command Controller

This block is the software-facing register file of a simple UART channel. A processor reaches it through byte reads and writes over a 64-byte window. It holds two mode registers behind one address and an auto-advancing pointer. It also holds the status flags, the interrupt status and mask, the two baud divider bytes and a small receive FIFO. It executes the three fields of a command byte in one write: a miscellaneous reset, a transmitter enable or disable, and a receiver enable or disable.

On the transmit side one holding byte is kept and offered to an external serializer through a valid/ready handshake. The transmitter counts as empty again only when that handshake completes. On the receive side the block accepts bytes from an external deserializer through a valid/ready handshake. A line-break event stores a zero byte, overwriting the newest entry when the FIFO is full. Read data is combinational while the read strobe is high. A read of the receive data offset removes the head entry at the clock edge that ends the read.

Top module: `uart_regblock`

## Requirements
- R1: Only address bits [5:0] are decoded. The offsets are: 0x00 mode, 0x04 status (read only, writes ignored), 0x08 command (write), 0x0C receive data on read and transmit data on write, 0x14 interrupt status on read and interrupt mask on write, 0x18 and 0x1C the low and high baud divider bytes (write and read back). Offset 0x10 and unmapped offsets read zero, and writes to them change nothing. busRdData is zero whenever busRd is low.
- R2: A write to 0x00 loads the mode register chosen by the pointer and then points at the second mode register. A read of 0x00 returns the chosen register. The pointer starts at the first register.
- R3: Status bits are: bit0 receive data present, bit1 FIFO full, bit2 transmitter ready, bit3 transmitter empty. Bits 7..4 (overrun, parity, framing, break) read zero.
- R4: Command bits [3:2] act on the transmitter and bits [1:0] on the receiver: 1 enables, 2 disables, 0 and 3 change nothing. These fields take effect after the miscellaneous field of the same write, so an enable in the same byte as a reset leaves the unit enabled.
- R5: Command bits [6:4] are the miscellaneous field. Code 1 points the mode pointer at the first register. Code 2 disables the receiver and empties the FIFO. Code 3 disables the transmitter, drops any held byte and sets transmitter empty. Code 5 clears the break-change interrupt flag. Codes 0, 4, 6 and 7 change nothing, and bit 7 is ignored.
- R6: A write to 0x0C stores the byte and clears transmitter empty. txValid is high exactly while the transmitter is enabled and not empty. txData holds the stored byte while txValid is high. A cycle with txValid and txReady both high sets transmitter empty.
- R7: Transmitter ready (status bit2) equals the transmitter enable state at all times.
- R8: rxReady is high when the receiver is enabled, the FIFO (depth 4) is not full and no break is signalled. A byte is stored when rxValid and rxReady are both high. Reads of 0x0C return bytes in arrival order and remove each one. A read with the FIFO empty returns zero and changes nothing.
- R9: A cycle with rxBreak high sets the break-change flag and stores a zero byte even with the receiver disabled. When the FIFO is full and not being read, the zero replaces the newest entry.
- R10: Interrupt status is bit0 transmitter ready, bit1 receive interrupt and bit2 break-change flag. The receive interrupt means FIFO full when bit6 of the first mode register is 1, and data present otherwise. irq is high when any interrupt status bit is set in the mask.
- R11: After reset, both mode registers, the pointer, both enables, the break flag, the mask, the baud bytes and the FIFO are cleared, and status reads 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Write strobe, one byte per cycle |
| busRd | input | 1 | Read strobe |
| busAddr | input | 6 | Byte offset in the register window |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational while busRd is high |
| irq | output | 1 | Interrupt request |
| txValid | output | 1 | Held transmit byte offered to the serializer |
| txData | output | 8 | Held transmit byte |
| txReady | input | 1 | Serializer accepts the byte |
| rxValid | input | 1 | Deserializer offers a received byte |
| rxData | input | 8 | Received byte |
| rxReady | output | 1 | Block accepts a received byte |
| rxBreak | input | 1 | Line-break event, one pulse per break |

## Verification
The assertions check several rules on every cycle. The held transmit byte stays stable while the serializer stalls, and a completed handshake retires it. txValid never rises without transmitter ready. irq never rises with an empty mask. The FIFO count stays in range, a break into a full FIFO does not grow it, and a read of an empty FIFO leaves it empty. The bench's scenarios must show the rest: the mode pointer sequence, how the three command fields combine in one byte, the order of bytes out of the FIFO, the break overwrite of the newest entry, the choice of receive interrupt source, and which writes have no effect.

// File: rtl/uart_regblock_pkg.sv
`timescale 1ns/1ps
package uart_regblock_pkg;

  localparam logic [5:0] OFS_MODE  = 6'h00;
  localparam logic [5:0] OFS_STAT  = 6'h04;
  localparam logic [5:0] OFS_CMD   = 6'h08;
  localparam logic [5:0] OFS_DATA  = 6'h0C;
  localparam logic [5:0] OFS_INT   = 6'h14;
  localparam logic [5:0] OFS_BAUDL = 6'h18;
  localparam logic [5:0] OFS_BAUDH = 6'h1C;

  // status bit positions
  localparam int ST_RXRDY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMP = 3;

  // interrupt status bit positions
  localparam int IS_TX  = 0;
  localparam int IS_RX  = 1;
  localparam int IS_BRK = 2;

  // first mode register: receive interrupt source select
  localparam int MR_RXFULL_SEL = 6;

  localparam int MODE_REGS = 2;

  typedef enum logic [2:0] {
    RD_ZERO, RD_MODE, RD_STAT, RD_RXD, RD_INT, RD_BAUDL, RD_BAUDH
  } rdSel_e;

  typedef struct packed {
    logic   wrMode;
    logic   wrTb;
    logic   wrImr;
    logic   wrBaudL;
    logic   wrBaudH;
    logic   popRx;
    logic   ptrReset;
    logic   rxFlush;
    logic   txFlush;
    logic   clrBreak;
    logic   txEnSet;
    logic   txEnClr;
    logic   rxEnSet;
    logic   rxEnClr;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/uart_reg_ctrl.sv
`timescale 1ns/1ps
module uart_reg_ctrl
  import uart_regblock_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [6:0]        cmdBits,
  output strobes_t          strb
);

  logic [2:0] miscCode;
  logic [1:0] txField;
  logic [1:0] rxField;
  logic [5:0] ofs;

  assign miscCode = cmdBits[6:4];
  assign txField  = cmdBits[3:2];
  assign rxField  = cmdBits[1:0];
  assign ofs      = busAddr[5:0];

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_ZERO;
    if (busWr) begin
      unique case (ofs)
        OFS_MODE:  strb.wrMode  = 1'b1;
        OFS_DATA:  strb.wrTb    = 1'b1;
        OFS_INT:   strb.wrImr   = 1'b1;
        OFS_BAUDL: strb.wrBaudL = 1'b1;
        OFS_BAUDH: strb.wrBaudH = 1'b1;
        OFS_CMD: begin
          strb.ptrReset = (miscCode == 3'd1);
          strb.rxFlush  = (miscCode == 3'd2);
          strb.txFlush  = (miscCode == 3'd3);
          strb.clrBreak = (miscCode == 3'd5);
          // enable fields act after the miscellaneous field
          strb.txEnSet  = (txField == 2'd1);
          strb.txEnClr  = (txField == 2'd2) || (miscCode == 3'd3);
          strb.rxEnSet  = (rxField == 2'd1);
          strb.rxEnClr  = (rxField == 2'd2) || (miscCode == 3'd2);
        end
        default: ;
      endcase
    end
    if (busRd) begin
      unique case (ofs)
        OFS_MODE:  strb.rdSel = RD_MODE;
        OFS_STAT:  strb.rdSel = RD_STAT;
        OFS_INT:   strb.rdSel = RD_INT;
        OFS_BAUDL: strb.rdSel = RD_BAUDL;
        OFS_BAUDH: strb.rdSel = RD_BAUDH;
        OFS_DATA: begin
          strb.rdSel = RD_RXD;
          strb.popRx = 1'b1;
        end
        default: strb.rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] lastPtr;
  logic [CNT_W-1:0] cnt;
  logic             doPop;
  logic             doPush;
  logic             overwrite;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (cnt == CNT_W'(DEPTH));
  assign empty     = (cnt == '0);
  assign doPop     = pop && !empty;
  assign overwrite = push && full && !doPop;
  assign doPush    = push && !overwrite;
  assign lastPtr   = (wrPtr == '0) ? PTR_W'(DEPTH - 1) : wrPtr - 1'b1;
  assign head      = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!clear) begin
      if (doPush) begin
        mem[wrPtr] <= pushData;
      end else if (overwrite) begin
        mem[lastPtr] <= pushData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else if (clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPop)  rdPtr <= bump(rdPtr);
      if (doPush) wrPtr <= bump(wrPtr);
      cnt <= cnt + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH)); // R8

  AST_FULL_NOGROW: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !clear) |=> full); // R9

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push && !clear) |=> empty); // R8

endmodule

// File: rtl/uart_reg_datapath.sv
`timescale 1ns/1ps
module uart_reg_datapath
  import uart_regblock_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  input  logic              rxBreak
);

  logic [DATA_W-1:0] modeReg [MODE_REGS];
  logic              modePtr;
  logic              txEn;
  logic              rxEn;
  logic              txEmpty;
  logic [DATA_W-1:0] txBuf;
  logic              breakFlag;
  logic [DATA_W-1:0] imr;
  logic [DATA_W-1:0] baudL;
  logic [DATA_W-1:0] baudH;

  logic              fifoFull;
  logic              fifoEmpty;
  logic [DATA_W-1:0] fifoHead;
  logic              fifoPush;
  logic [DATA_W-1:0] fifoPushData;

  logic [DATA_W-1:0] statusVec;
  logic [DATA_W-1:0] intVec;
  logic              rxInt;

  // mode registers behind the auto-advancing pointer
  for (genvar i = 0; i < MODE_REGS; i++) begin : g_mode
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeReg[i] <= '0;
      end else if (strb.wrMode && (modePtr == 1'(i))) begin
        modeReg[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modePtr <= 1'b0;
    end else if (strb.wrMode) begin
      modePtr <= 1'b1;
    end else if (strb.ptrReset) begin
      modePtr <= 1'b0;
    end
  end

  // enables: set beats clear, since the enable field follows the reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn <= 1'b0;
      rxEn <= 1'b0;
    end else begin
      if (strb.txEnSet)      txEn <= 1'b1;
      else if (strb.txEnClr) txEn <= 1'b0;
      if (strb.rxEnSet)      rxEn <= 1'b1;
      else if (strb.rxEnClr) rxEn <= 1'b0;
    end
  end

  // transmit holding byte
  assign txValid = txEn && !txEmpty;
  assign txData  = txBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmpty <= 1'b1;
      txBuf   <= '0;
    end else begin
      if (strb.wrTb) txBuf <= wrData;
      if (strb.txFlush)             txEmpty <= 1'b1;
      else if (strb.wrTb)           txEmpty <= 1'b0;
      else if (txValid && txReady)  txEmpty <= 1'b1;
    end
  end

  // plain configuration bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      imr   <= '0;
      baudL <= '0;
      baudH <= '0;
    end else begin
      if (strb.wrImr)   imr   <= wrData;
      if (strb.wrBaudL) baudL <= wrData;
      if (strb.wrBaudH) baudH <= wrData;
    end
  end

  // break-change flag: a new break wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      breakFlag <= 1'b0;
    end else if (rxBreak) begin
      breakFlag <= 1'b1;
    end else if (strb.clrBreak) begin
      breakFlag <= 1'b0;
    end
  end

  // receive path
  assign rxReady      = rxEn && !fifoFull && !rxBreak;
  assign fifoPush     = rxBreak || (rxValid && rxReady);
  assign fifoPushData = rxBreak ? '0 : rxData;

  uart_rx_fifo #(
    .DEPTH (RX_DEPTH),
    .W     (DATA_W)
  ) u_rx_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (strb.rxFlush),
    .push     (fifoPush),
    .pushData (fifoPushData),
    .pop      (strb.popRx),
    .head     (fifoHead),
    .full     (fifoFull),
    .empty    (fifoEmpty)
  );

  // status and interrupt vectors
  assign rxInt = modeReg[0][MR_RXFULL_SEL] ? fifoFull : !fifoEmpty;

  always_comb begin
    statusVec           = '0;
    statusVec[ST_RXRDY] = !fifoEmpty;
    statusVec[ST_FULL]  = fifoFull;
    statusVec[ST_TXRDY] = txEn;
    statusVec[ST_TXEMP] = txEmpty;
    intVec              = '0;
    intVec[IS_TX]       = txEn;
    intVec[IS_RX]       = rxInt;
    intVec[IS_BRK]      = breakFlag;
  end

  assign irq = |(intVec & imr);

  always_comb begin
    unique case (strb.rdSel)
      RD_MODE:  rdData = modeReg[modePtr];
      RD_STAT:  rdData = statusVec;
      RD_RXD:   rdData = fifoEmpty ? '0 : fifoHead;
      RD_INT:   rdData = intVec;
      RD_BAUDL: rdData = baudL;
      RD_BAUDH: rdData = baudH;
      default:  rdData = '0;
    endcase
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !strb.wrTb && !strb.txEnClr) |=> (txValid && $stable(txData))); // R6

  AST_TX_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && !strb.wrTb) |=> !txValid); // R6

  AST_TXVALID_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> statusVec[ST_TXRDY]); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (imr != '0)); // R10

endmodule

// File: rtl/uart_regblock.sv
`timescale 1ns/1ps
module uart_regblock
  import uart_regblock_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  input  logic              rxBreak
);

  strobes_t strb;

  uart_reg_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .cmdBits (busWrData[6:0]),
    .strb    (strb)
  );

  uart_reg_datapath #(
    .DATA_W   (DATA_W),
    .RX_DEPTH (RX_DEPTH)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .irq     (irq),
    .txValid (txValid),
    .txData  (txData),
    .txReady (txReady),
    .rxValid (rxValid),
    .rxData  (rxData),
    .rxReady (rxReady),
    .rxBreak (rxBreak)
  );

endmodule

// File: tb/uart_regblock_bench.sv
`timescale 1ns/1ps
module uart_regblock_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [5:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       irq;
  logic       txValid;
  logic [7:0] txData;
  logic       txReady = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxReady;
  logic       rxBreak = 1'b0;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_regblock u_uart_regblock (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irq(irq), .txValid(txValid),
    .txData(txData), .txReady(txReady), .rxValid(rxValid), .rxData(rxData),
    .rxReady(rxReady), .rxBreak(rxBreak)
  );

  // behavioural reference model
  logic [7:0] mMr [2];
  int         mPtr;
  bit         mTxEn, mRxEn, mTxEmpty, mBrk;
  logic [7:0] mTb, mImr, mBaudL, mBaudH;
  logic [7:0] q[$];

  function automatic logic [7:0] mStatus();
    return {4'b0, mTxEmpty, mTxEn, (q.size() == 4), (q.size() != 0)};
  endfunction

  function automatic logic [7:0] mInt();
    bit rxi;
    rxi = mMr[0][6] ? (q.size() == 4) : (q.size() != 0);
    return {5'b0, mBrk, rxi, mTxEn};
  endfunction

  function automatic logic [7:0] mRead(logic [5:0] a);
    case (a)
      6'h00: return mMr[mPtr];
      6'h04: return mStatus();
      6'h0C: return (q.size() != 0) ? q[0] : 8'h00;
      6'h14: return mInt();
      6'h18: return mBaudL;
      6'h1C: return mBaudH;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rdTag(logic [5:0] a);
    case (a)
      6'h00: return "R2";
      6'h04: return "R3";
      6'h0C: return "R8";
      6'h14: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mMr[0] = 0; mMr[1] = 0; mPtr = 0; mTxEn = 0; mRxEn = 0; mTxEmpty = 1;
    mBrk = 0; mTb = 0; mImr = 0; mBaudL = 0; mBaudH = 0; q.delete();
  endtask

  task automatic modelStep();
    bit hs, rxRdyPre, popPre, flush, clrB;
    logic [2:0] misc;
    hs = mTxEn && !mTxEmpty && txReady && !(busWr && busAddr == 6'h0C);
    rxRdyPre = mRxEn && (q.size() < 4) && !rxBreak;
    popPre = busRd && (busAddr == 6'h0C) && (q.size() != 0);
    flush = 0; clrB = 0;
    if (busWr) begin
      case (busAddr)
        6'h00: begin mMr[mPtr] = busWrData; mPtr = 1; end
        6'h08: begin
          misc = busWrData[6:4];
          if (misc == 1) mPtr = 0;
          if (misc == 2) begin mRxEn = 0; flush = 1; end
          if (misc == 3) begin mTxEn = 0; mTxEmpty = 1; end
          if (misc == 5) clrB = 1;
          if (busWrData[3:2] == 1) mTxEn = 1;
          if (busWrData[3:2] == 2) mTxEn = 0;
          if (busWrData[1:0] == 1) mRxEn = 1;
          if (busWrData[1:0] == 2) mRxEn = 0;
        end
        6'h0C: begin mTb = busWrData; mTxEmpty = 0; end
        6'h14: mImr = busWrData;
        6'h18: mBaudL = busWrData;
        6'h1C: mBaudH = busWrData;
        default: ;
      endcase
    end
    if (hs) mTxEmpty = 1;
    if (flush) q.delete();
    else begin
      if (popPre) void'(q.pop_front());
      if (rxBreak) begin
        if (q.size() == 4) q[3] = 8'h00;
        else q.push_back(8'h00);
      end else if (rxValid && rxRdyPre) q.push_back(rxData);
    end
    if (rxBreak) mBrk = 1;
    else if (clrB) mBrk = 0;
  endtask

  // compare every cycle, then advance the model at the edge
  task automatic tick();
    bit ev;
    #1;
    chk(rdTag(busAddr), busRdData, busRd ? mRead(busAddr) : 8'h00);
    ev = mTxEn && !mTxEmpty;
    chk("R6", txValid, ev);
    if (ev) chk("R6", txData, mTb);
    chk("R8", rxReady, mRxEn && (q.size() < 4) && !rxBreak);
    chk("R10", irq, (mInt() & mImr) != 0);
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic wrReg(logic [5:0] a, logic [7:0] d);
    busWr = 1; busAddr = a; busWrData = d;
    tick();
    busWr = 0; busAddr = 0; busWrData = 0;
  endtask

  task automatic rdChk(logic [5:0] a, logic [7:0] exp, string tag);
    busRd = 1; busAddr = a;
    #1 chk(tag, busRdData, exp);
    tick();
    busRd = 0; busAddr = 0;
  endtask

  task automatic rxByte(logic [7:0] d);
    rxValid = 1; rxData = d;
    tick();
    rxValid = 0; rxData = 0;
  endtask

  task automatic brk();
    rxBreak = 1;
    tick();
    rxBreak = 0;
  endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R11 reset state
    rdChk(6'h04, 8'h08, "R11");
    rdChk(6'h00, 8'h00, "R11");
    rdChk(6'h14, 8'h00, "R11");
    chk("R11", {irq, txValid, rxReady}, 3'b000);

    // R2 mode pointer
    wrReg(6'h00, 8'hA5);
    wrReg(6'h00, 8'h3C);
    rdChk(6'h00, 8'h3C, "R2");
    rdChk(6'h00, 8'h3C, "R2");
    wrReg(6'h08, 8'h10);
    rdChk(6'h00, 8'hA5, "R2");
    wrReg(6'h00, 8'h11);
    rdChk(6'h00, 8'h3C, "R2");

    // R1 map and ignored writes
    wrReg(6'h18, 8'h12);
    wrReg(6'h1C, 8'h34);
    rdChk(6'h18, 8'h12, "R1");
    rdChk(6'h1C, 8'h34, "R1");
    wrReg(6'h04, 8'hFF);
    wrReg(6'h10, 8'hFF);
    wrReg(6'h24, 8'hFF);
    rdChk(6'h04, 8'h08, "R1");
    rdChk(6'h10, 8'h00, "R1");
    rdChk(6'h3C, 8'h00, "R1");
    rdChk(6'h14, 8'h00, "R1");

    // R6 transmit holding byte and handshake
    wrReg(6'h0C, 8'h55);
    rdChk(6'h04, 8'h00, "R6");
    chk("R6", txValid, 1'b0);
    wrReg(6'h08, 8'h04);
    chk("R7", {txValid, txData}, {1'b1, 8'h55});
    rdChk(6'h04, 8'h04, "R7");
    repeat (3) tick();
    chk("R6", {txValid, txData}, {1'b1, 8'h55});
    txReady = 1;
    tick();
    txReady = 0;
    rdChk(6'h04, 8'h0C, "R6");

    // R7 disable while pending, then R5 transmitter reset
    wrReg(6'h0C, 8'h66);
    wrReg(6'h08, 8'h08);
    chk("R7", txValid, 1'b0);
    rdChk(6'h04, 8'h00, "R7");
    wrReg(6'h08, 8'h04);
    chk("R4", {txValid, txData}, {1'b1, 8'h66});
    wrReg(6'h08, 8'h30);
    rdChk(6'h04, 8'h08, "R5");
    chk("R5", txValid, 1'b0);

    // R4 all three fields in one byte
    wrReg(6'h08, 8'h35);
    rdChk(6'h04, 8'h0C, "R4");
    chk("R4", rxReady, 1'b1);

    // R8 FIFO order, full, ignored byte, empty read
    rxByte(8'h11); rxByte(8'h22); rxByte(8'h33); rxByte(8'h44);
    chk("R8", rxReady, 1'b0);
    rdChk(6'h04, 8'h0F, "R3");
    rxByte(8'h99);
    rdChk(6'h0C, 8'h11, "R8");
    rdChk(6'h0C, 8'h22, "R8");
    rdChk(6'h0C, 8'h33, "R8");
    rdChk(6'h0C, 8'h44, "R8");
    rdChk(6'h0C, 8'h00, "R8");
    rdChk(6'h04, 8'h0C, "R8");

    // R9 break into a full FIFO
    rxByte(8'hA1); rxByte(8'hA2); rxByte(8'hA3); rxByte(8'hA4);
    brk();
    rdChk(6'h14, 8'h07, "R9");
    rdChk(6'h0C, 8'hA1, "R9");
    rdChk(6'h0C, 8'hA2, "R9");
    rdChk(6'h0C, 8'hA3, "R9");
    rdChk(6'h0C, 8'h00, "R9");
    wrReg(6'h08, 8'h50);
    rdChk(6'h14, 8'h01, "R5");

    // R10 interrupt mask and receive source select
    wrReg(6'h14, 8'h02);
    chk("R10", irq, 1'b0);
    rxByte(8'h77);
    chk("R10", irq, 1'b1);
    wrReg(6'h08, 8'h10);
    wrReg(6'h00, 8'h40);
    chk("R10", irq, 1'b0);
    rxByte(8'h78); rxByte(8'h79); rxByte(8'h7A);
    chk("R10", irq, 1'b1);

    // R5 receiver reset and no-effect codes
    wrReg(6'h08, 8'h20);
    chk("R5", {irq, rxReady}, 2'b00);
    rdChk(6'h04, 8'h0C, "R5");
    wrReg(6'h08, 8'h40);
    wrReg(6'h08, 8'h60);
    wrReg(6'h08, 8'hF0);
    rdChk(6'h04, 8'h0C, "R5");
    rdChk(6'h00, 8'h3C, "R5");

    // R4 receiver enable/disable and reserved codes
    wrReg(6'h08, 8'h01);
    chk("R4", rxReady, 1'b1);
    wrReg(6'h08, 8'h02);
    chk("R4", rxReady, 1'b0);
    wrReg(6'h08, 8'h0F);
    rdChk(6'h04, 8'h0C, "R4");
    chk("R4", rxReady, 1'b0);

    // R9 break with receiver disabled, then R10 transmitter interrupt
    brk();
    rdChk(6'h04, 8'h0D, "R9");
    wrReg(6'h14, 8'h01);
    chk("R10", irq, 1'b1);
    repeat (2) tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule